// File: doc/BRIEF.md
# Fast Ethernet PCS transmit path

This block turns the transmit side of a media-independent interface into a serial 100BASE-X code stream. Once per nibble period it takes a 4-bit data nibble together with the transmit-enable and transmit-error flags. It frames each packet with start and end delimiters and maps every nibble to a 5-bit code-group. The code-groups are shifted out one bit per bit clock, and the line level is NRZI coded. In copper operation the code bits are scrambled by a free-running 11-stage LFSR before NRZI. In fiber operation the scrambler is bypassed.

The nibble clock and the bit clock are phase-locked with a ratio of five. Because of that, the block runs entirely on the bit clock and marks the nibble boundary with a one-cycle strobe, `nib_tick`. The MAC presents a new nibble for each strobe. The block also produces carrier sense and collision from its own transmit activity and a receive-carrier input.

Top module: `pcs_tx_top`

## Requirements
- R1: `nib_tick` is high for exactly one bit clock in every five. It is high in the first cycle after reset. The MII inputs are sampled at the rising edge that ends a cycle in which `nib_tick` is high.
- R2: Data nibbles are mapped to code-groups, written with the first-sent bit leftmost: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. The leftmost bit of each code-group leaves first.
- R3: When the frame is idle, the first sampled nibble with transmit enable high sends J (11000) and the next nibble sends K (10001), whatever their data values. Data code-groups follow. The first nibble with enable low after data sends T (01101) and the next sends R (00111). Idle (11111) is sent otherwise.
- R4: A data nibble sampled with transmit error high is sent as H (00100) in place of its data code-group.
- R5: Transmit error with transmit enable low outside a frame has no effect: idle code-groups continue.
- R6: NRZI: the line level toggles for each transmitted 1 and holds for each 0. After reset the line level is 0.
- R7: In copper mode (`fiber_mode` = 0), each transmitted bit is the code bit XOR a keystream bit s = q[10] XOR q[8] of an 11-bit register q. At each bit clock, q shifts left with s entering at q[0]. q is held at all ones during reset and advances every bit clock in both modes.
- R8: In fiber mode (`fiber_mode` = 1), code bits reach the NRZI stage unscrambled.
- R9: `crs` is registered. One bit clock after any cycle in which the receive carrier is high, or in which the transmitter is busy, it reads 1; otherwise it reads 0. The transmitter is busy from the edge that samples the J nibble until the edge that samples the R nibble.
- R10: `col` is registered and reads, one bit clock later, receive carrier AND transmitter busy. It is never 1 while no frame is being sent.
- R11: While reset is held, `tx_line`, `crs` and `col` are 0. The first code-group sent after reset is idle when the enable input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (nibble clock is one fifth, phase-locked) |
| rst | input | 1 | Synchronous active-high reset |
| mii_txd | input | 4 | Transmit data nibble |
| mii_tx_en | input | 1 | Transmit enable |
| mii_tx_er | input | 1 | Transmit error |
| rx_carrier | input | 1 | Receive-side carrier present |
| fiber_mode | input | 1 | 1 = fiber (scrambler bypassed), 0 = copper (scrambled) |
| nib_tick | output | 1 | Nibble strobe; inputs are taken at the edge ending this cycle |
| tx_line | output | 1 | NRZI serial line level |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
The bench decodes the serial line itself. It undoes the NRZI, removes its own keystream in copper mode, and regroups the bits into code-groups, which it compares against the expected code-group sequence.

The frame of all sixteen nibble values in fiber mode checks the mapping table and the bit order with no scrambler in the path. The same frame in copper mode shows that the keystream is applied with the correct polynomial, seed and alignment. Frames with an error nibble, back-to-back frames and error pulses between frames separate the H substitution from the idle behaviour.

Receive carrier is raised both while idle and inside a frame, which separates carrier sense from collision.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef logic [CG_W-1:0]  cg_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_H    = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SSD2,
        ST_DATA,
        ST_ESD2
    } tx_st_e;

    // data nibble to code-group, leftmost bit sent first (R2)
    function automatic cg_t enc_4b5b(input nib_t n);
        cg_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
    import pcs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  nib_t txd,
    input  logic tx_en,
    input  logic tx_er,
    output logic nib_tick,
    output cg_t  cg_next,
    output logic busy
);

    localparam int             PH_W    = $clog2(CG_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CG_W - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        tx_st_e          st;
    } fr_s;

    fr_s    r_d, r_q;
    tx_st_e st_n;

    always_comb begin
        r_d     = r_q;
        st_n    = r_q.st;
        cg_next = CG_IDLE;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tx_en) begin
                    cg_next = CG_J;
                    st_n    = ST_SSD2;
                end
            end
            ST_SSD2: begin
                cg_next = CG_K;
                st_n    = ST_DATA;
            end
            ST_DATA: begin
                if (tx_en) begin
                    cg_next = tx_er ? CG_H : enc_4b5b(txd);
                end else begin
                    cg_next = CG_T;
                    st_n    = ST_ESD2;
                end
            end
            ST_ESD2: begin
                cg_next = CG_R;
                st_n    = ST_IDLE;
            end
        endcase
        r_d.ph = (r_q.ph == PH_LAST) ? '0 : r_q.ph + 1'b1;
        if (r_q.ph == '0) begin
            r_d.st = st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.ph <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign nib_tick = (r_q.ph == '0);
    assign busy     = (r_q.st != ST_IDLE);

    // R1: the strobe never lasts two cycles
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        nib_tick |=> !nib_tick);

    // R3: K always follows J one nibble earlier
    assert_k_after_j_R3: assert property (@(posedge clk) disable iff (rst)
        (nib_tick && cg_next == CG_K) |-> ($past(cg_next, 5) == CG_J));

    // R3: R always follows T one nibble earlier
    assert_r_after_t_R3: assert property (@(posedge clk) disable iff (rst)
        (nib_tick && cg_next == CG_R) |-> ($past(cg_next, 5) == CG_T));

endmodule

// File: rtl/pcs_tx_serializer.sv
module pcs_tx_serializer
    import pcs_tx_pkg::*;
#(
    parameter int                LFSR_W   = 11,
    parameter int                LFSR_TAP = 9,
    parameter logic [LFSR_W-1:0] SEED     = '1,
    parameter bit                SCR_EN   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cg_t  cg_in,
    input  logic bypass,
    output logic line
);

    typedef struct packed {
        cg_t              sh;
        logic [LFSR_W-1:0] lfsr;
        logic             line;
    } ser_s;

    ser_s s_d, s_q;
    logic fb;
    logic ks;
    logic tx_bit;

    assign fb = s_q.lfsr[LFSR_W-1] ^ s_q.lfsr[LFSR_TAP-1];

    generate
        if (SCR_EN) begin : g_scr
            assign ks = fb & ~bypass;
        end else begin : g_noscr
            assign ks = 1'b0;
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        tx_bit   = s_q.sh[CG_W-1] ^ ks;
        s_d.line = s_q.line ^ tx_bit;
        s_d.lfsr = {s_q.lfsr[LFSR_W-2:0], fb};
        s_d.sh   = load ? cg_in : {s_q.sh[CG_W-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.sh   <= CG_IDLE;
            s_q.lfsr <= SEED;
            s_q.line <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line = s_q.line;

    // R7: the keystream register never locks up at zero
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        s_q.lfsr != '0);

    // R8: unscrambled ones always flip the line in fiber mode
    assert_fiber_one_toggles_R8: assert property (@(posedge clk) disable iff (rst)
        (bypass && s_q.sh[CG_W-1]) |=> (line != $past(line)));

endmodule

// File: rtl/pcs_tx_sense.sv
module pcs_tx_sense (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rx_carrier,
    output logic crs,
    output logic col
);

    typedef struct packed {
        logic crs;
        logic col;
    } sn_s;

    sn_s n_d, n_q;

    always_comb begin
        n_d     = n_q;
        n_d.crs = busy | rx_carrier;
        n_d.col = busy & rx_carrier;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= '0;
        end else begin
            n_q <= n_d;
        end
    end

    assign crs = n_q.crs;
    assign col = n_q.col;

    // R10: a collision is always also carrier
    assert_col_implies_crs_R10: assert property (@(posedge clk) disable iff (rst)
        col |-> crs);

endmodule

// File: rtl/pcs_tx_top.sv
module pcs_tx_top
    import pcs_tx_pkg::*;
#(
    parameter int                  LFSR_W    = 11,
    parameter int                  LFSR_TAP  = 9,
    parameter logic [LFSR_W-1:0]   LFSR_SEED = '1,
    parameter bit                  SCR_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mii_txd,
    input  logic       mii_tx_en,
    input  logic       mii_tx_er,
    input  logic       rx_carrier,
    input  logic       fiber_mode,
    output logic       nib_tick,
    output logic       tx_line,
    output logic       crs,
    output logic       col
);

    cg_t  cg_next;
    logic busy;

    pcs_tx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .txd      (mii_txd),
        .tx_en    (mii_tx_en),
        .tx_er    (mii_tx_er),
        .nib_tick (nib_tick),
        .cg_next  (cg_next),
        .busy     (busy)
    );

    pcs_tx_serializer #(
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP),
        .SEED     (LFSR_SEED),
        .SCR_EN   (SCR_EN)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (nib_tick),
        .cg_in  (cg_next),
        .bypass (fiber_mode),
        .line   (tx_line)
    );

    pcs_tx_sense u_sense (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .rx_carrier (rx_carrier),
        .crs        (crs),
        .col        (col)
    );

    // R11: reset quiets every output
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (!tx_line && !crs && !col));

endmodule

// File: tb/pcs_tx_top_tb_top.sv
`timescale 1ns/100ps
module pcs_tx_top_tb_top;

    localparam logic [4:0] C_I = 5'b11111;
    localparam logic [4:0] C_J = 5'b11000;
    localparam logic [4:0] C_K = 5'b10001;
    localparam logic [4:0] C_T = 5'b01101;
    localparam logic [4:0] C_R = 5'b00111;
    localparam logic [4:0] C_H = 5'b00100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mii_txd = '0;
    logic       mii_tx_en = 1'b0;
    logic       mii_tx_er = 1'b0;
    logic       rx_carrier = 1'b0;
    logic       fiber_mode = 1'b1;
    logic       nib_tick, tx_line, crs, col;

    always #2.5 clk = ~clk;

    pcs_tx_top dut_i (
        .clk(clk), .rst(rst), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
        .mii_tx_er(mii_tx_er), .rx_carrier(rx_carrier), .fiber_mode(fiber_mode),
        .nib_tick(nib_tick), .tx_line(tx_line), .crs(crs), .col(col)
    );

    int checks = 0;
    int errors = 0;

    // expected and observed code-group logs
    logic [4:0] exp_cg [0:255];
    string      exp_tag[0:255];
    int         nib_n = 0;
    logic [4:0] log_cg [0:255];
    int         log_n = 0;

    // line monitor: NRZI decode, descramble, regroup
    logic        rst_at_edge, copper_at_edge;
    logic [10:0] mon_lfsr;
    logic        mon_line, mon_skip, mon_s, mon_b;
    logic [4:0]  mon_sh;
    int          mon_bits;

    always @(posedge clk) begin
        rst_at_edge    <= rst;
        copper_at_edge <= ~fiber_mode;
    end

    always @(negedge clk) begin
        if (rst_at_edge) begin
            mon_lfsr = 11'h7FF;
            mon_line = 1'b0;
            mon_skip = 1'b1;
            mon_bits = 0;
            mon_sh   = '0;
            log_n    = 0;
        end else begin
            mon_s    = mon_lfsr[10] ^ mon_lfsr[8];      // R7 keystream
            mon_b    = (tx_line ^ mon_line) ^ (copper_at_edge & mon_s); // R6 decode
            mon_lfsr = {mon_lfsr[9:0], mon_s};
            mon_line = tx_line;
            if (mon_skip) begin
                mon_skip = 1'b0;
            end else begin
                mon_sh   = {mon_sh[3:0], mon_b};
                mon_bits = mon_bits + 1;
                if (mon_bits == 5) begin
                    if (log_n < 256) log_cg[log_n] = mon_sh;
                    log_n    = log_n + 1;
                    mon_bits = 0;
                end
            end
        end
    end

    function automatic logic [4:0] code_of(input logic [3:0] n);
        logic [4:0] t [0:15];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic er, input logic [3:0] d,
                        input logic [4:0] e, input string tag);
        @(negedge clk);
        while (!nib_tick) @(negedge clk);
        mii_tx_en = en;
        mii_tx_er = er;
        mii_txd   = d;
        if (nib_n < 256) begin
            exp_cg[nib_n]  = e;
            exp_tag[nib_n] = tag;
        end
        nib_n++;
    endtask

    task automatic apply_reset(input logic fiber);
        @(negedge clk);
        rst = 1'b1;
        fiber_mode = fiber;
        mii_tx_en = 1'b0; mii_tx_er = 1'b0; mii_txd = '0; rx_carrier = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_cg[0]  = C_I;   // first load after reset, enable low (R11)
        exp_tag[0] = "R11";
        nib_n = 1;
    endtask

    task automatic finish_stream();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'h0, C_I, "R3");
        repeat (12) @(negedge clk);
        for (int i = 0; i < nib_n; i++) begin
            if (i >= log_n)
                chk(1'b0, exp_tag[i], "code-group missing", log_n, i + 1);
            else
                chk(log_cg[i] == exp_cg[i], exp_tag[i], "code-group",
                    int'(log_cg[i]), int'(exp_cg[i]));
        end
    endtask

    task automatic send_frame(input int n, input int start, input int er_at,
                              input string dtag);
        step(1'b1, 1'b0, 4'h5, C_J, "R3");
        step(1'b1, 1'b0, 4'h5, C_K, "R3");
        for (int i = 0; i < n; i++) begin
            if (i == er_at) step(1'b1, 1'b1, 4'(start + i), C_H, "R4");
            else step(1'b1, 1'b0, 4'(start + i), code_of(4'(start + i)), dtag);
        end
        step(1'b0, 1'b0, 4'h0, C_T, "R3");
        step(1'b0, 1'b0, 4'h0, C_R, "R3");
    endtask

    // reset outputs, strobe cadence, fiber idle toggling (R1, R6, R11)
    task automatic t_reset_and_cadence();
        int gap;
        logic prev;
        @(negedge clk);
        rst = 1'b1; fiber_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b0, "R11", "line in reset", tx_line, 0);
        chk(crs == 1'b0, "R11", "crs in reset", crs, 0);
        chk(col == 1'b0, "R11", "col in reset", col, 0);
        rst = 1'b0;
        chk(nib_tick == 1'b1, "R1", "tick first cycle", nib_tick, 1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!nib_tick);
        chk(gap == 5, "R1", "tick period", gap, 5);
        @(negedge clk);
        chk(nib_tick == 1'b0, "R1", "tick width", nib_tick, 0);
        prev = tx_line;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(tx_line != prev, "R6", "idle ones toggle line", tx_line, !prev);
            prev = tx_line;
        end
    endtask

    // fiber frame with every nibble value (R2, R3, R8)
    task automatic t_fiber_table();
        apply_reset(1'b1);
        step(1'b0, 1'b0, 4'h0, C_I, "R8");
        send_frame(16, 0, -1, "R2");
        finish_stream();
    endtask

    // copper frame with an error nibble (R4, R7)
    task automatic t_copper_frame();
        apply_reset(1'b0);
        step(1'b0, 1'b0, 4'h0, C_I, "R7");
        step(1'b0, 1'b0, 4'h0, C_I, "R7");
        send_frame(16, 3, 7, "R7");
        finish_stream();
    endtask

    // error outside frames ignored, back-to-back frames (R5, R3)
    task automatic t_idle_error();
        apply_reset(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 4'(9 + i), C_I, "R5");
        send_frame(3, 10, -1, "R2");
        send_frame(2, 1, 1, "R2");
        step(1'b0, 1'b1, 4'hF, C_I, "R5");
        finish_stream();
    endtask

    // carrier sense and collision (R9, R10)
    task automatic t_sense();
        apply_reset(1'b0);
        step(1'b0, 1'b0, 4'h0, C_I, "R9");
        rx_carrier = 1'b1;
        repeat (2) @(negedge clk);
        chk(crs == 1'b1, "R9", "crs from receive while idle", crs, 1);
        chk(col == 1'b0, "R10", "no col while idle", col, 0);
        rx_carrier = 1'b0;
        repeat (2) @(negedge clk);
        chk(crs == 1'b0, "R9", "crs drops when idle", crs, 0);
        step(1'b1, 1'b0, 4'h5, C_J, "R3");
        step(1'b1, 1'b0, 4'h5, C_K, "R3");
        step(1'b1, 1'b0, 4'h1, code_of(4'h1), "R2");
        step(1'b1, 1'b0, 4'h2, code_of(4'h2), "R2");
        rx_carrier = 1'b1;
        @(negedge clk);
        chk(col == 1'b1, "R10", "col in frame with carrier", col, 1);
        chk(crs == 1'b1, "R9", "crs in frame", crs, 1);
        rx_carrier = 1'b0;
        @(negedge clk);
        chk(col == 1'b0, "R10", "col drops with carrier", col, 0);
        chk(crs == 1'b1, "R9", "crs held by transmit", crs, 1);
        step(1'b0, 1'b0, 4'h0, C_T, "R3");
        step(1'b0, 1'b0, 4'h0, C_R, "R3");
        finish_stream();
        chk(crs == 1'b0, "R9", "crs after frame", crs, 0);
    endtask

    initial begin
        t_reset_and_cadence();
        t_fiber_table();
        t_copper_frame();
        t_idle_error();
        t_sense();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule